// File: doc/BRIEF.md
# Tamper Latch with Time-Stamp Freeze

This block sits beside the timekeeping counters of a real-time clock. It watches an external tamper pin and, once software has armed it with a tamper-enable bit, latches a read-only tamper flag the moment the pin goes high. On that same event, the copy of the time that the host reads is frozen. The host therefore finds the exact second, minute and hour of the intrusion in the clock registers. The internal counters keep counting while the copy is frozen, so no time is lost.

Software reads the frozen stamp and then writes the enable bit to 0. The flag drops once the pin is also low. The host view then still shows the stamp until the serial bus signals a stop condition, or until the address pointer has moved into RAM space and come back to the clock registers. After that the host sees the current time again. The enable bit has no defined power-up value, so firmware must write it to 0 before relying on the block.

Top module: `tamper_stamp_top`

## Requirements
- R1: After reset and an initial write of 0 to the enable bit, `tamper_flag` is 0, `tamper_en` is 0, and the read time (hour, minute, second) is 0:0:0.
- R2: With `tamper_en` at 1, a high level on `tamper_pin` passes a two-flop synchronizer and sets `tamper_flag` on the third rising clock edge after the pin rises. The flag is still 0 after the second edge.
- R3: While `tamper_en` is 0, any pattern on `tamper_pin` leaves `tamper_flag` at 0, and the read time keeps following the live time.
- R4: The flag has no write path. With `tamper_en` at 1 it stays set after the pin returns low.
- R5: The flag clears only when `tamper_en` is 0 and the synchronized pin is low. Writing the enable bit to 0 while the pin is still high keeps the flag set until the pin goes low.
- R6: While the flag is set, the read time holds the live time at the tamper event and does not change, even as one-second ticks advance the live counters. The host view is never the live time while the flag is set.
- R7: After the flag clears, the read time still shows the stamp. Pulsing `ptr_ram_enter` alone, or `bus_stop` while the flag is still set, does not resume it. A `bus_stop` pulse, or `ptr_ram_enter` followed later by `ptr_clk_enter`, switches the view back to the live time from the next edge on.
- R8: Each `sec_tick` cycle advances the live time by one second. Seconds wrap from 59 to 0 and carry into minutes, minutes wrap from 59 to 0 and carry into hours, and hours wrap from 23 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset (does not touch the enable bit) |
| tamper_pin | input | 1 | Asynchronous tamper pin level |
| en_wr | input | 1 | Write strobe for the tamper-enable bit |
| en_wr_data | input | 1 | Value written to the tamper-enable bit |
| sec_tick | input | 1 | One-cycle pulse per elapsed second |
| bus_stop | input | 1 | Stop condition seen on the host bus |
| ptr_ram_enter | input | 1 | Address pointer moved to a RAM address |
| ptr_clk_enter | input | 1 | Address pointer moved back to a clock register |
| tamper_en | output | 1 | Current tamper-enable bit |
| tamper_flag | output | 1 | Read-only tamper status |
| rd_sec | output | 6 | Host-visible seconds, binary 0..59 |
| rd_min | output | 6 | Host-visible minutes, binary 0..59 |
| rd_hour | output | 5 | Host-visible hours, binary 0..23 |

## Verification
On every cycle, the assertions check four things: the flag rises only with the enable bit and the synchronized pin high, it falls only with both low, the host view is never the live time while the flag is set, and the view leaves the stale state only after a stop or a pointer return. They also check that the frozen read time does not change while the flag stays set. Other behaviours need the bench scenarios. These are the three-edge set latency, whether the stamp equals the time at the moment the pin rose, the counters running on during a freeze, the ordering of pointer moves to RAM and back, and the full-day wrap of seconds, minutes and hours.

// File: rtl/tamper_stamp_pkg.sv
package tamper_stamp_pkg;

    localparam int SEC_W     = 6;
    localparam int MIN_W     = 6;
    localparam int HOUR_W    = 5;
    localparam int SEC_LAST  = 59;
    localparam int MIN_LAST  = 59;
    localparam int HOUR_LAST = 23;

    typedef struct packed {
        logic [HOUR_W-1:0] hour;
        logic [MIN_W-1:0]  min;
        logic [SEC_W-1:0]  sec;
    } rtc_time_t;

    typedef enum logic [1:0] {
        VIEW_LIVE  = 2'd0,
        VIEW_HELD  = 2'd1,
        VIEW_STALE = 2'd2
    } view_state_e;

    function automatic rtc_time_t time_step(input rtc_time_t t);
        rtc_time_t n;
        n = t;
        if (t.sec == SEC_W'(SEC_LAST)) begin
            n.sec = '0;
            if (t.min == MIN_W'(MIN_LAST)) begin
                n.min  = '0;
                n.hour = (t.hour == HOUR_W'(HOUR_LAST)) ? '0 : t.hour + 1'b1;
            end else begin
                n.min = t.min + 1'b1;
            end
        end else begin
            n.sec = t.sec + 1'b1;
        end
        return n;
    endfunction

endpackage

// File: rtl/tamper_sync.sv
module tamper_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-2:0], din};
    end

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/tamper_latch.sv
module tamper_latch (
    input  logic clk,
    input  logic rst,
    input  logic en_wr,
    input  logic en_wr_data,
    input  logic pin_s,
    output logic en_q,
    output logic flag,
    output logic set_now
);
    // Enable bit deliberately has no reset: its power-up value is undefined.
    always_ff @(posedge clk) begin
        if (en_wr) en_q <= en_wr_data;
    end

    assign set_now = en_q & pin_s & ~flag;

    always_ff @(posedge clk) begin
        if (rst)                 flag <= 1'b0;
        else if (set_now)        flag <= 1'b1;
        else if (!en_q && !pin_s) flag <= 1'b0;
    end
endmodule

// File: rtl/rtc_live_counter.sv
module rtc_live_counter
    import tamper_stamp_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      tick,
    output rtc_time_t live
);
    always_ff @(posedge clk) begin
        if (rst)       live <= '0;
        else if (tick) live <= time_step(live);
    end
endmodule

// File: rtl/stamp_view_ctrl.sv
module stamp_view_ctrl
    import tamper_stamp_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        flag,
    input  logic        set_now,
    input  rtc_time_t   live,
    input  logic        bus_stop,
    input  logic        ptr_ram_enter,
    input  logic        ptr_clk_enter,
    output view_state_e view_q,
    output rtc_time_t   rd_time
);
    rtc_time_t shadow;
    logic      in_ram;

    always_ff @(posedge clk) begin
        if (rst) begin
            view_q <= VIEW_LIVE;
            shadow <= '0;
            in_ram <= 1'b0;
        end else if (set_now) begin
            view_q <= VIEW_HELD;
            shadow <= live;
            in_ram <= 1'b0;
        end else begin
            unique case (view_q)
                VIEW_LIVE: shadow <= live;
                VIEW_HELD: begin
                    if (!flag) begin
                        view_q <= VIEW_STALE;
                        in_ram <= 1'b0;
                    end
                end
                VIEW_STALE: begin
                    if (bus_stop || (in_ram && ptr_clk_enter)) view_q <= VIEW_LIVE;
                    else if (ptr_ram_enter)                     in_ram <= 1'b1;
                end
                default: view_q <= VIEW_LIVE;
            endcase
        end
    end

    assign rd_time = (view_q == VIEW_LIVE) ? live : shadow;
endmodule

// File: rtl/tamper_stamp_top.sv
module tamper_stamp_top
    import tamper_stamp_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tamper_pin,
    input  logic              en_wr,
    input  logic              en_wr_data,
    input  logic              sec_tick,
    input  logic              bus_stop,
    input  logic              ptr_ram_enter,
    input  logic              ptr_clk_enter,
    output logic              tamper_en,
    output logic              tamper_flag,
    output logic [SEC_W-1:0]  rd_sec,
    output logic [MIN_W-1:0]  rd_min,
    output logic [HOUR_W-1:0] rd_hour
);
    logic        pin_s;
    logic        set_now;
    rtc_time_t   live;
    rtc_time_t   rd_time;
    view_state_e view_q;

    tamper_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .din(tamper_pin), .dout(pin_s)
    );

    tamper_latch u_latch (
        .clk(clk), .rst(rst), .en_wr(en_wr), .en_wr_data(en_wr_data),
        .pin_s(pin_s), .en_q(tamper_en), .flag(tamper_flag), .set_now(set_now)
    );

    rtc_live_counter u_live (
        .clk(clk), .rst(rst), .tick(sec_tick), .live(live)
    );

    stamp_view_ctrl u_view (
        .clk(clk), .rst(rst), .flag(tamper_flag), .set_now(set_now),
        .live(live), .bus_stop(bus_stop), .ptr_ram_enter(ptr_ram_enter),
        .ptr_clk_enter(ptr_clk_enter), .view_q(view_q), .rd_time(rd_time)
    );

    assign rd_sec  = rd_time.sec;
    assign rd_min  = rd_time.min;
    assign rd_hour = rd_time.hour;
endmodule

// File: rtl/tamper_stamp_chk.sv
module tamper_stamp_chk
    import tamper_stamp_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic        tamper_en,
    input logic        tamper_flag,
    input logic        pin_s,
    input logic        bus_stop,
    input logic        ptr_clk_enter,
    input view_state_e view_q,
    input rtc_time_t   rd_time,
    input rtc_time_t   live
);
    // R2
    flag_rise_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(tamper_flag) |-> ($past(tamper_en) && $past(pin_s)));

    // R5
    flag_fall_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(tamper_flag) |-> (!$past(tamper_en) && !$past(pin_s)));

    // R6
    stamp_frozen_chk: assert property (@(posedge clk) disable iff (rst)
        (tamper_flag && $past(tamper_flag)) |-> $stable(rd_time));

    // R6
    flag_hides_live_chk: assert property (@(posedge clk) disable iff (rst)
        tamper_flag |-> (view_q != VIEW_LIVE));

    // R7
    resume_cause_chk: assert property (@(posedge clk) disable iff (rst)
        ((view_q == VIEW_LIVE) && ($past(view_q) == VIEW_STALE))
            |-> ($past(bus_stop) || $past(ptr_clk_enter)));

    // R8
    live_range_chk: assert property (@(posedge clk) disable iff (rst)
        (live.sec <= SEC_W'(SEC_LAST)) && (live.min <= MIN_W'(MIN_LAST))
            && (live.hour <= HOUR_W'(HOUR_LAST)));
endmodule

bind tamper_stamp_top tamper_stamp_chk u_chk (
    .clk(clk), .rst(rst), .tamper_en(tamper_en), .tamper_flag(tamper_flag),
    .pin_s(pin_s), .bus_stop(bus_stop), .ptr_clk_enter(ptr_clk_enter),
    .view_q(view_q), .rd_time(rd_time), .live(live)
);

// File: tb/tamper_stamp_top_tb.sv
`timescale 1ns/1ps
module tamper_stamp_top_tb;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tamper_pin = 0, en_wr = 0, en_wr_data = 0, sec_tick = 0;
    logic bus_stop = 0, ptr_ram_enter = 0, ptr_clk_enter = 0;
    logic tamper_en, tamper_flag;
    logic [5:0] rd_sec, rd_min;
    logic [4:0] rd_hour;

    int n_chk = 0, n_fail = 0;
    int es = 0, em = 0, eh = 0;
    int snap;
    bit done = 0;

    always #4 clk = ~clk;

    tamper_stamp_top u_dut (
        .clk(clk), .rst(rst), .tamper_pin(tamper_pin), .en_wr(en_wr),
        .en_wr_data(en_wr_data), .sec_tick(sec_tick), .bus_stop(bus_stop),
        .ptr_ram_enter(ptr_ram_enter), .ptr_clk_enter(ptr_clk_enter),
        .tamper_en(tamper_en), .tamper_flag(tamper_flag),
        .rd_sec(rd_sec), .rd_min(rd_min), .rd_hour(rd_hour)
    );

    function automatic int pack_time(int h, int m, int s);
        return (h << 12) | (m << 6) | s;
    endfunction

    function automatic int rd_word();
        return pack_time(int'(rd_hour), int'(rd_min), int'(rd_sec));
    endfunction

    function automatic int exp_word();
        return pack_time(eh, em, es);
    endfunction

    task automatic exp_advance();
        if (es == 59) begin
            es = 0;
            if (em == 59) begin em = 0; eh = (eh == 23) ? 0 : eh + 1; end
            else em = em + 1;
        end else es = es + 1;
    endtask

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        #1;
    endtask

    task automatic wait_n(input int n);
        for (int i = 0; i < n; i++) cyc();
    endtask

    task automatic ticks(input int n);
        sec_tick = 1'b1;
        for (int i = 0; i < n; i++) begin
            cyc();
            exp_advance();
        end
        sec_tick = 1'b0;
    endtask

    task automatic write_en(input bit v);
        en_wr = 1'b1; en_wr_data = v;
        cyc();
        en_wr = 1'b0;
    endtask

    task automatic pulse(ref logic sig);
        sig = 1'b1;
        cyc();
        sig = 1'b0;
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            summary();
            $finish;
        end
    end

    initial begin
        int seed;
        seed = $urandom(32'h5EED_0042);
        wait_n(3);
        rst = 1'b0;
        write_en(1'b0);
        check(tamper_flag == 1'b0, "R1 flag", tamper_flag, 0);
        check(tamper_en == 1'b0, "R1 enable", tamper_en, 0);
        check(rd_word() == 0, "R1 time", rd_word(), 0);

        // R8 carry and wrap boundaries over a full day
        ticks(59);
        check(rd_word() == pack_time(0, 0, 59), "R8 sec 59", rd_word(), pack_time(0, 0, 59));
        ticks(1);
        check(rd_word() == pack_time(0, 1, 0), "R8 min carry", rd_word(), pack_time(0, 1, 0));
        ticks(3540);
        check(rd_word() == pack_time(1, 0, 0), "R8 hour carry", rd_word(), pack_time(1, 0, 0));
        ticks(82799);
        check(rd_word() == pack_time(23, 59, 59), "R8 day end", rd_word(), pack_time(23, 59, 59));
        ticks(1);
        check(rd_word() == 0, "R8 day wrap", rd_word(), 0);

        // R3 random pin and ticks with enable off
        for (int i = 0; i < 300; i++) begin
            bit t;
            t = ($urandom % 2) == 1;
            sec_tick = t;
            tamper_pin = ($urandom % 2) == 1;
            cyc();
            if (t) exp_advance();
            check(tamper_flag == 1'b0, "R3 flag", tamper_flag, 0);
            check(rd_word() == exp_word(), "R3 view", rd_word(), exp_word());
        end
        sec_tick = 0; tamper_pin = 0;
        wait_n(3);
        ticks(int'($urandom % 200) + 10);

        // first event: R2 latency, R6 freeze, R4 hold, R7 pointer resume
        write_en(1'b1);
        snap = exp_word();
        tamper_pin = 1'b1;
        wait_n(2);
        check(tamper_flag == 1'b0, "R2 two edges", tamper_flag, 0);
        cyc();
        check(tamper_flag == 1'b1, "R2 third edge", tamper_flag, 1);
        check(rd_word() == snap, "R6 stamp", rd_word(), snap);
        ticks(7);
        check(rd_word() == snap, "R6 frozen during ticks", rd_word(), snap);
        pulse(bus_stop);
        check(rd_word() == snap, "R7 stop ignored while flagged", rd_word(), snap);
        tamper_pin = 1'b0;
        wait_n(4);
        check(tamper_flag == 1'b1, "R4 flag held", tamper_flag, 1);
        write_en(1'b0);
        wait_n(2);
        check(tamper_flag == 1'b0, "R5 cleared", tamper_flag, 0);
        check(rd_word() == snap, "R7 stale after clear", rd_word(), snap);
        pulse(ptr_ram_enter);
        wait_n(2);
        check(rd_word() == snap, "R7 RAM move alone", rd_word(), snap);
        pulse(ptr_clk_enter);
        check(rd_word() == exp_word(), "R7 pointer back resumes", rd_word(), exp_word());
        ticks(3);
        check(rd_word() == exp_word(), "R6 counters ran on", rd_word(), exp_word());

        // second event: R5 clear blocked by pin, R7 stop resume
        write_en(1'b1);
        snap = exp_word();
        tamper_pin = 1'b1;
        wait_n(3);
        check(tamper_flag == 1'b1, "R2 second event", tamper_flag, 1);
        write_en(1'b0);
        ticks(5);
        check(tamper_flag == 1'b1, "R5 pin high keeps flag", tamper_flag, 1);
        check(rd_word() == snap, "R6 second stamp", rd_word(), snap);
        tamper_pin = 1'b0;
        wait_n(2);
        check(tamper_flag == 1'b1, "R5 sync delay", tamper_flag, 1);
        wait_n(2);
        check(tamper_flag == 1'b0, "R5 cleared after pin low", tamper_flag, 0);
        check(rd_word() == snap, "R7 stale before stop", rd_word(), snap);
        pulse(bus_stop);
        check(rd_word() == exp_word(), "R7 stop resumes", rd_word(), exp_word());

        done = 1;
        summary();
        $finish;
    end
endmodule